// File: doc/BRIEF.md
# Indexed Block-Access Serial Register Slave

This block is a slave on a two-wire SMBus-style bus. A fast system clock oversamples the clock line and the data line, and the block finds START, repeated START and STOP conditions in the sampled values. It answers a single fixed 7-bit device address and holds a small file of byte registers. The write form of that address is D4h and the read form is D5h.

Every transfer names a starting register index. A write then gives a byte count, followed by that many data bytes, which land at consecutive indices. A read sets the index in a write-form preamble, turns the bus around with a repeated START and the read-form address, and then receives a count byte first and the data bytes after it. The slave pulls the data line low and never drives it high. It changes the line only while the clock line is low.

Top module: `smbus_block_slave`

## Requirements
- R1: After reset the slave releases the data line (`sdaOe` = 0), and every register reads back as 00h.
- R2: After a START or a repeated START, the slave takes the next eight bits as an address byte. It ACKs address byte D4h (write) and address byte D5h (read), with the most significant bit sent first.
- R3: The slave NACKs any other address byte. It then ignores all bus traffic, and ACKs nothing and stores nothing, until the next START.
- R4: In a write, the slave ACKs the byte after the address as the starting index N and the byte after that as the count X. It stores data bytes at indices N, N+1, and so on, one increment per data byte.
- R5: The slave NACKs a data byte that arrives after X data bytes have already been accepted in the same write, and does not store it.
- R6: A write aimed at an index at or above the register count (8) is ACKed and has no effect on any register.
- R7: In a read, the first byte the slave sends after ACKing D5h is the number of implemented registers (08h).
- R8: After the count byte, a read returns the registers from the index set by the preamble. The index advances once per data byte the host ACKs. Indices at or above 8 read as 00h.
- R9: When the host NACKs a byte it has received, the slave stops transmitting and leaves the data line released until the next START.
- R10: The slave starts pulling the data line low only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sdaOe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The hardest case to reach from the ports is a host NACK inside a read, followed by more clocking with no new START. It must leave the slave silent, and this is only visible because the line stays high while the bus is clocked. The bench gets there by ending a read early with a NACK. It then clocks a further full byte as a receiver and expects FFh, which shows that the slave is not driving. A second hard case is a data byte beyond the declared count. The bench sends one surplus byte in a write, expects a NACK, and reads back the neighbouring register to show that the byte was not stored.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_SLV_ACK,
    ST_TX,
    ST_HOST_ACK
  } smbState_t;

  typedef enum logic [1:0] {
    PH_IDX,
    PH_CNT,
    PH_DATA
  } smbPhase_t;

  typedef struct packed {
    logic loadIdx;
    logic incIdx;
    logic loadRem;
    logic decRem;
    logic wrReg;
    logic loadTx;
    logic selCnt;
    logic shiftTx;
  } smbStrobe_t;

endpackage

// File: rtl/smb_datapath.sv
module smb_datapath
  import smb_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int IDX_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  smbStrobe_t strb,
  output logic       sclS,
  output logic       sdaS,
  output logic       sclRise,
  output logic       sclFall,
  output logic       startDet,
  output logic       stopDet,
  output logic [7:0] rxByte,
  output logic       txFirstBit,
  output logic       txNextBit,
  output logic       remZero
);

  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclD, sdaD;
  logic [7:0] rxShift, txShift, txByte, rdData, remCnt;
  logic [IDX_W-1:0] idx;
  logic [7:0] regs [NUM_REGS];
  logic inRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  assign inRange = (idx < LAST_IDX);
  assign rdData  = inRange ? regs[idx[SEL_W-1:0]] : 8'h00;
  assign txByte  = strb.selCnt ? 8'(NUM_REGS) : rdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      idx     <= '0;
      remCnt  <= '0;
    end else begin
      if (sclRise) rxShift <= {rxShift[6:0], sdaS};
      if (strb.loadTx)       txShift <= txByte;
      else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b0};
      if (strb.loadIdx)     idx <= IDX_W'(rxShift);
      else if (strb.incIdx) idx <= idx + 1'b1;
      if (strb.loadRem)     remCnt <= rxShift;
      else if (strb.decRem) remCnt <= remCnt - 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regs[g] <= 8'h00;
        else if (strb.wrReg && inRange && idx[SEL_W-1:0] == SEL_W'(g)) regs[g] <= rxShift;
      end
    end
  endgenerate

  assign rxByte     = rxShift;
  assign txFirstBit = txByte[7];
  assign txNextBit  = txShift[6];
  assign remZero    = (remCnt == 8'h00);

endmodule

// File: rtl/smb_control.sv
module smb_control
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaS,
  input  logic [7:0] rxByte,
  input  logic       txFirstBit,
  input  logic       txNextBit,
  input  logic       remZero,
  output smbStrobe_t strb,
  output logic       sdaOe
);

  smbState_t state;
  smbPhase_t phase;
  logic [3:0] bitCnt;
  logic readMode, sentData, hostAcked;
  logic rxDone, dataOk;

  assign rxDone = sclFall && (bitCnt == 4'd8);
  assign dataOk = (state == ST_RX) && rxDone && (phase == PH_DATA) && !remZero;

  always_comb begin
    strb         = '0;
    strb.loadIdx = (state == ST_RX) && rxDone && (phase == PH_IDX);
    strb.loadRem = (state == ST_RX) && rxDone && (phase == PH_CNT);
    strb.wrReg   = dataOk;
    strb.decRem  = dataOk;
    strb.incIdx  = dataOk || ((state == ST_HOST_ACK) && sclRise && !sdaS && sentData);
    strb.selCnt  = (state == ST_SLV_ACK);
    strb.loadTx  = ((state == ST_SLV_ACK) && sclFall && readMode) ||
                   ((state == ST_HOST_ACK) && sclFall && hostAcked);
    strb.shiftTx = (state == ST_TX) && sclFall && (bitCnt != 4'd8);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= PH_IDX;
      bitCnt    <= '0;
      readMode  <= 1'b0;
      sentData  <= 1'b0;
      hostAcked <= 1'b0;
      sdaOe     <= 1'b0;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
      sdaOe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (sclRise && bitCnt != 4'd8) bitCnt <= bitCnt + 1'b1;
          if (rxDone) begin
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                sdaOe    <= 1'b1;
                state    <= ST_SLV_ACK;
                readMode <= rxByte[0];
                phase    <= PH_IDX;
              end else begin
                state <= ST_IDLE;
              end
            end else if (phase == PH_DATA && remZero) begin
              state <= ST_IDLE;
            end else begin
              sdaOe <= 1'b1;
              state <= ST_SLV_ACK;
              if (phase == PH_IDX)      phase <= PH_CNT;
              else if (phase == PH_CNT) phase <= PH_DATA;
            end
          end
        end
        ST_SLV_ACK: begin
          if (sclFall) begin
            if (readMode) begin
              state    <= ST_TX;
              sdaOe    <= ~txFirstBit;
              bitCnt   <= 4'd1;
              sentData <= 1'b0;
            end else begin
              state  <= ST_RX;
              sdaOe  <= 1'b0;
              bitCnt <= '0;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd8) begin
              sdaOe     <= 1'b0;
              state     <= ST_HOST_ACK;
              hostAcked <= 1'b0;
            end else begin
              sdaOe  <= ~txNextBit;
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_HOST_ACK: begin
          if (sclRise) begin
            if (sdaS) state <= ST_IDLE;
            else      hostAcked <= 1'b1;
          end else if (sclFall && hostAcked) begin
            state    <= ST_TX;
            sdaOe    <= ~txFirstBit;
            bitCnt   <= 4'd1;
            sentData <= 1'b1;
          end
        end
        default: sdaOe <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/smbus_block_slave.sv
module smbus_block_slave
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h6A,
  parameter int         NUM_REGS    = 8,
  parameter int         IDX_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  smbStrobe_t strb;
  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic txFirstBit, txNextBit, remZero;
  logic [7:0] rxByte;

  smb_datapath #(
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .rxByte(rxByte),
    .txFirstBit(txFirstBit), .txNextBit(txNextBit), .remZero(remZero)
  );

  smb_control #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS), .rxByte(rxByte),
    .txFirstBit(txFirstBit), .txNextBit(txNextBit), .remZero(remZero),
    .strb(strb), .sdaOe(sdaOe)
  );

endmodule

// File: rtl/smb_checker.sv
module smb_checker
  import smb_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sdaOe,
  input logic       sclS,
  input logic       startDet,
  input logic       stopDet,
  input logic       remZero,
  input smbStrobe_t strb
);

  AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS); // R10

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe); // R2

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe); // R9

  AST_WRITE_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrReg |-> !remZero); // R5

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadIdx, strb.loadRem, strb.wrReg, strb.loadTx})); // R4

endmodule

bind smbus_block_slave smb_checker uChk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclS(sclS), .startDet(startDet),
  .stopDet(stopDet), .remZero(remZero), .strb(strb)
);

// File: tb/tb_smbus_block_slave.sv
module tb_smbus_block_slave;

  localparam int HP = 16;
  localparam int QP = 4;
  localparam int NREG = 8;
  localparam logic [7:0] WADDR = 8'hD4;
  localparam logic [7:0] RADDR = 8'hD5;

  // {index, write data, expected readback}
  localparam logic [23:0] VEC [6] = '{
    {8'd0,   8'hA5, 8'hA5},
    {8'd3,   8'h3C, 8'h3C},
    {8'd7,   8'hFF, 8'hFF},
    {8'd8,   8'h55, 8'h00},
    {8'd200, 8'h12, 8'h00},
    {8'd6,   8'h5A, 8'h5A}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclHost = 1'b1;
  logic sdaHost = 1'b1;
  logic sdaOe;
  logic sdaLine;
  int nChk = 0;
  int nFail = 0;
  int badEdges = 0;
  logic prevOe = 1'b0;
  logic [7:0] wrBuf [8];
  logic [7:0] rdBuf [8];

  always #2 clk = ~clk;
  assign sdaLine = sdaHost & ~sdaOe;

  smbus_block_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclHost), .sdaIn(sdaLine), .sdaOe(sdaOe)
  );

  always @(negedge clk) begin
    if (rstN && sdaOe != prevOe && sclHost) badEdges++;
    prevOe = sdaOe;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaHost = 1'b1; waitc(HP);
    sclHost = 1'b1; waitc(HP);
    sdaHost = 1'b0; waitc(HP);
    sclHost = 1'b0; waitc(QP);
  endtask

  task automatic stopCond();
    sdaHost = 1'b0; waitc(HP);
    sclHost = 1'b1; waitc(HP);
    sdaHost = 1'b1; waitc(HP);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaHost = b[i]; waitc(HP);
      sclHost = 1'b1; waitc(HP);
      sclHost = 1'b0; waitc(QP);
    end
    sdaHost = 1'b1; waitc(HP);
    sclHost = 1'b1; waitc(HP / 2);
    ack = ~sdaLine; waitc(HP / 2);
    sclHost = 1'b0; waitc(QP);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    sdaHost = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(HP);
      sclHost = 1'b1; waitc(HP / 2);
      b[i] = sdaLine; waitc(HP / 2);
      sclHost = 1'b0; waitc(QP);
    end
    sdaHost = nack; waitc(HP);
    sclHost = 1'b1; waitc(HP);
    sclHost = 1'b0; waitc(QP);
    sdaHost = 1'b1;
  endtask

  // returns ack bits: [0] address, [1] index, [2] count, [3+k] data k
  task automatic wrBlock(input logic [7:0] idx, input logic [7:0] cnt,
                         input int nData, output logic [10:0] acks);
    logic a;
    acks = '0;
    startCond();
    sendByte(WADDR, a); acks[0] = a;
    sendByte(idx, a);   acks[1] = a;
    sendByte(cnt, a);   acks[2] = a;
    for (int k = 0; k < nData; k++) begin
      sendByte(wrBuf[k], a); acks[3+k] = a;
    end
    stopCond();
  endtask

  task automatic rdBlock(input logic [7:0] idx, input int nData,
                         output logic [7:0] cnt, output logic [2:0] acks);
    logic a;
    startCond();
    sendByte(WADDR, a); acks[0] = a;
    sendByte(idx, a);   acks[1] = a;
    startCond();
    sendByte(RADDR, a); acks[2] = a;
    recvByte(1'b0, cnt);
    for (int k = 0; k < nData; k++) recvByte(k == nData - 1, rdBuf[k]);
    stopCond();
  endtask

  initial begin
    logic [10:0] wa;
    logic [2:0] ra;
    logic [7:0] cnt;
    logic a;
    logic [7:0] b;
    waitc(10);
    rstN = 1'b1;
    waitc(10);
    chk("R1 sda released after reset", int'(sdaOe), 0);

    rdBlock(8'd0, 8, cnt, ra);
    for (int k = 0; k < 8; k++) chk("R1 register reset value", int'(rdBuf[k]), 0);

    for (int v = 0; v < 6; v++) begin
      wrBuf[0] = VEC[v][15:8];
      wrBlock(VEC[v][23:16], 8'd1, 1, wa);
      chk("R2 R4 R6 write acks", int'(wa[3:0]), 4'hF);
      rdBlock(VEC[v][23:16], 1, cnt, ra);
      chk("R2 read acks", int'(ra), 3'b111);
      chk("R7 count byte", int'(cnt), NREG);
      chk("R8 R6 readback", int'(rdBuf[0]), int'(VEC[v][7:0]));
    end

    // R4: multi-byte write with auto-increment
    wrBuf[0] = 8'h11; wrBuf[1] = 8'h22; wrBuf[2] = 8'h33;
    wrBlock(8'd1, 8'd3, 3, wa);
    chk("R4 multi-byte acks", int'(wa[5:0]), 6'h3F);
    rdBlock(8'd1, 3, cnt, ra);
    chk("R4 R8 idx1", int'(rdBuf[0]), 8'h11);
    chk("R4 R8 idx2", int'(rdBuf[1]), 8'h22);
    chk("R4 R8 idx3", int'(rdBuf[2]), 8'h33);

    // R5: byte beyond count is NACKed and not stored
    wrBuf[0] = 8'h44; wrBuf[1] = 8'h99;
    wrBlock(8'd4, 8'd1, 2, wa);
    chk("R5 in-count data ack", int'(wa[3]), 1);
    chk("R5 surplus data nack", int'(wa[4]), 0);
    rdBlock(8'd4, 2, cnt, ra);
    chk("R5 idx4 stored", int'(rdBuf[0]), 8'h44);
    chk("R5 idx5 untouched", int'(rdBuf[1]), 8'h00);

    // R8: read running past the last register
    rdBlock(8'd6, 3, cnt, ra);
    chk("R8 idx6", int'(rdBuf[0]), 8'h5A);
    chk("R8 idx7", int'(rdBuf[1]), 8'hFF);
    chk("R8 idx8 reads zero", int'(rdBuf[2]), 8'h00);

    // R3: wrong address NACKed, following bytes ignored
    startCond();
    sendByte(8'hA0, a);
    chk("R3 wrong address nack", int'(a), 0);
    sendByte(8'h00, a);
    chk("R3 ignored index byte", int'(a), 0);
    sendByte(8'h01, a);
    sendByte(8'h77, a);
    chk("R3 ignored data byte", int'(a), 0);
    stopCond();
    rdBlock(8'd0, 1, cnt, ra);
    chk("R3 register untouched", int'(rdBuf[0]), 8'hA5);

    // R9: host NACK silences slave until next START
    startCond();
    sendByte(WADDR, a);
    sendByte(8'd3, a);
    startCond();
    sendByte(RADDR, a);
    recvByte(1'b0, b);
    recvByte(1'b1, b);
    chk("R9 last data before nack", int'(b), 8'h33);
    chk("R9 sda released after nack", int'(sdaOe), 0);
    recvByte(1'b1, b);
    chk("R9 no drive after nack", int'(b), 8'hFF);
    stopCond();

    chk("R10 sda changes only with scl low", badEdges, 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    waitc(190000);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule